// File: doc/BRIEF.md
# UART Receive FIFO Timeout Detector

This block watches the receive FIFO of a UART and raises a timeout condition when received characters are left sitting in the FIFO with no traffic in either direction. The FIFO may hold fewer characters than its trigger level, and then no data-available request is made. Without a timeout, software could wait forever for data that is already there. The detector counts character times, not clock cycles. A one-cycle tick input marks each character time; the baud and frame logic outside the block derives it from the frame length at the current baud rate.

Any write into or read out of the FIFO restarts the count. Detection runs only in FIFO mode and only while the FIFO holds at least one character. No status bit shows the timeout. The raw pending flag goes to the interrupt prioritizer, together with a request output that is gated by the receive-data interrupt enable. The FIFO, the baud generator and the serial receiver are outside this block.

Top module: `uart_rx_idle_timer`

## Requirements
- R1: While `fifo_mode_en` is low, `tmo_pending` is low one cycle later and the character-time count is cleared, so ticks seen in that mode never contribute to a later timeout.
- R2: While FIFO mode is on and `rx_level` is non-zero, with no push or pop, `tmo_pending` rises on the clock edge that registers the `IDLE_CHARS`-th `char_tick` (default 4). After `IDLE_CHARS`-1 ticks it is still low.
- R3: A cycle with `rx_push` or `rx_pop` high restarts the count from zero and clears `tmo_pending` on the next edge. If a tick arrives in the same cycle, the access wins and the tick is not counted.
- R4: A cycle with `rx_level` equal to zero clears the count and `tmo_pending`. After the FIFO fills again, a full `IDLE_CHARS` ticks are needed.
- R5: `tmo_irq` equals `tmo_pending` when `rda_int_en` is high and is low otherwise. The enable does not affect counting: raising the enable after the condition has formed shows the request at once.
- R6: The count saturates at `IDLE_CHARS`. Further ticks neither wrap the count nor clear the flag.
- R7: Once set, `tmo_pending` stays high while the FIFO is idle and non-empty in FIFO mode, until a push, a pop, an empty FIFO or FIFO mode off clears it.
- R8: During and straight after reset, `tmo_pending` and `tmo_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_mode_en | input | 1 | High when the receive path runs in FIFO mode |
| rx_level | input | LVL_W | Current receive FIFO occupancy |
| rx_push | input | 1 | One-cycle strobe: a character was written into the FIFO |
| rx_pop | input | 1 | One-cycle strobe: a character was read from the FIFO |
| char_tick | input | 1 | One-cycle strobe marking the end of one character time |
| rda_int_en | input | 1 | Receive-data interrupt enable, which also gates the timeout request |
| tmo_pending | output | 1 | Registered timeout condition, to the prioritizer |
| tmo_irq | output | 1 | Timeout request gated by `rda_int_en` |

## Verification
The hardest situation to reach is a tick that lands in the same cycle as a FIFO access, or in the cycle where the FIFO is empty. Only exact cycle alignment shows whether that tick was wrongly counted. The bench drives all inputs on the falling edge, so it can place a tick in the same cycle as a push or an empty level. It then counts the remaining ticks one by one and checks that the flag rises exactly on the fourth tick after the restart, not the third. The saturation case is reached by letting many ticks pass unanswered after the flag has set.

// File: rtl/uart_rx_idle_pkg.sv
package uart_rx_idle_pkg;

    // Decision taken each cycle by the qualifier for the counter and flag.
    typedef enum logic [1:0] {
        ACT_IDLE    = 2'd0,  // detection disabled or FIFO empty: clear all
        ACT_RESTART = 2'd1,  // FIFO access: clear count and flag
        ACT_ADVANCE = 2'd2,  // character time elapsed with no access
        ACT_HOLD    = 2'd3   // nothing happened
    } idle_act_e;

endpackage

// File: rtl/uart_rx_idle_qual.sv
module uart_rx_idle_qual
    import uart_rx_idle_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic             fifo_mode_en,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             char_tick,
    output idle_act_e        act
);

    logic fifo_live;

    always_comb begin
        fifo_live = fifo_mode_en && (rx_level != '0);
        if (!fifo_live) begin
            act = ACT_IDLE;
        end else if (rx_push || rx_pop) begin
            act = ACT_RESTART;   // access beats a coincident tick (R3)
        end else if (char_tick) begin
            act = ACT_ADVANCE;
        end else begin
            act = ACT_HOLD;
        end
    end

endmodule

// File: rtl/uart_rx_idle_count.sv
module uart_rx_idle_count
    import uart_rx_idle_pkg::*;
#(
    parameter int IDLE_CHARS = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  idle_act_e act,
    output logic      reach
);

    localparam int CNT_W = $clog2(IDLE_CHARS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(IDLE_CHARS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(IDLE_CHARS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        reach = 1'b0;
        case (act)
            ACT_IDLE, ACT_RESTART: st_d.cnt = '0;
            ACT_ADVANCE: begin
                if (st_q.cnt != CNT_MAX) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
                reach = (st_q.cnt == CNT_LAST);
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_cnt_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_MAX);

    p_cnt_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_RESTART) |=> (st_q.cnt == '0));

    p_cnt_idle_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_IDLE) |=> (st_q.cnt == '0));

endmodule

// File: rtl/uart_rx_idle_flag.sv
module uart_rx_idle_flag
    import uart_rx_idle_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  idle_act_e act,
    input  logic      reach,
    output logic      flag
);

    typedef struct packed {
        logic set;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (act)
            ACT_IDLE, ACT_RESTART: st_d.set = 1'b0;
            ACT_ADVANCE: if (reach) st_d.set = 1'b1;
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.set;

    p_flag_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && (act == ACT_HOLD || act == ACT_ADVANCE)) |=> flag);

    p_flag_rise_on_reach_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(reach));

endmodule

// File: rtl/uart_rx_idle_timer.sv
module uart_rx_idle_timer
    import uart_rx_idle_pkg::*;
#(
    parameter int LVL_W      = 5,
    parameter int IDLE_CHARS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_mode_en,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             char_tick,
    input  logic             rda_int_en,
    output logic             tmo_pending,
    output logic             tmo_irq
);

    idle_act_e act;
    logic      reach;

    uart_rx_idle_qual #(.LVL_W(LVL_W)) qual_i (
        .fifo_mode_en (fifo_mode_en),
        .rx_level     (rx_level),
        .rx_push      (rx_push),
        .rx_pop       (rx_pop),
        .char_tick    (char_tick),
        .act          (act)
    );

    uart_rx_idle_count #(.IDLE_CHARS(IDLE_CHARS)) count_i (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (act),
        .reach (reach)
    );

    uart_rx_idle_flag flag_i (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (act),
        .reach (reach),
        .flag  (tmo_pending)
    );

    assign tmo_irq = tmo_pending && rda_int_en;

    p_nonfifo_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_mode_en |=> !tmo_pending);

    p_access_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push || rx_pop) |=> !tmo_pending);

    p_empty_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == '0) |=> !tmo_pending);

    p_rise_needs_idle_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_pending) |->
            $past(char_tick && fifo_mode_en && (rx_level != '0) && !rx_push && !rx_pop));

endmodule

// File: tb/uart_rx_idle_timer_tb_top.sv
`timescale 1ns/1ps
module uart_rx_idle_timer_tb_top;

    localparam int LVL_W = 5;
    localparam int N     = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             fifo_mode_en = 1'b0;
    logic [LVL_W-1:0] rx_level = '0;
    logic             rx_push = 1'b0;
    logic             rx_pop = 1'b0;
    logic             char_tick = 1'b0;
    logic             rda_int_en = 1'b0;
    logic             tmo_pending;
    logic             tmo_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    uart_rx_idle_timer #(.LVL_W(LVL_W), .IDLE_CHARS(N)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .fifo_mode_en (fifo_mode_en),
        .rx_level     (rx_level),
        .rx_push      (rx_push),
        .rx_pop       (rx_pop),
        .char_tick    (char_tick),
        .rda_int_en   (rda_int_en),
        .tmo_pending  (tmo_pending),
        .tmo_irq      (tmo_irq)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // One tick cycle; returns at the falling edge after it was registered.
    task automatic tick(input int count);
        for (int i = 0; i < count; i++) begin
            char_tick = 1'b1;
            @(negedge clk);
            char_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic strobe_push();
        rx_push = 1'b1;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic strobe_pop();
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R8 pending in reset", tmo_pending, 1'b0);
        check("R8 irq in reset", tmo_irq, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 pending after reset", tmo_pending, 1'b0);
    endtask

    task automatic t_nonfifo();
        fifo_mode_en = 1'b0;
        rx_level = 5'd3;
        rda_int_en = 1'b1;
        tick(N + 2);
        check("R1 no timeout out of FIFO mode", tmo_pending, 1'b0);
        fifo_mode_en = 1'b1;
        tick(N - 1);
        check("R1 earlier ticks not counted", tmo_pending, 1'b0);
        tick(1);
        check("R1 fresh count completes", tmo_pending, 1'b1);
        fifo_mode_en = 1'b0;
        @(negedge clk);
        check("R1 mode off clears flag", tmo_pending, 1'b0);
        fifo_mode_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_basic();
        rx_level = 5'd1;
        strobe_pop();
        tick(N - 1);
        check("R2 low before last tick", tmo_pending, 1'b0);
        tick(1);
        check("R2 high on last tick", tmo_pending, 1'b1);
        check("R5 irq follows with enable", tmo_irq, 1'b1);
        repeat (5) @(negedge clk);
        check("R7 holds while idle", tmo_pending, 1'b1);
    endtask

    task automatic t_access();
        strobe_push();
        check("R3 push clears flag", tmo_pending, 1'b0);
        rx_level = 5'd2;
        tick(N - 1);
        strobe_push();
        tick(N - 1);
        check("R3 push mid-count restarts", tmo_pending, 1'b0);
        tick(1);
        check("R3 full count after push", tmo_pending, 1'b1);
        strobe_pop();
        check("R3 pop clears flag", tmo_pending, 1'b0);
        tick(N - 1);
        rx_pop = 1'b1;
        char_tick = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
        char_tick = 1'b0;
        tick(N - 1);
        check("R3 tick with access not counted", tmo_pending, 1'b0);
        tick(1);
        check("R3 count completes after coincident access", tmo_pending, 1'b1);
    endtask

    task automatic t_empty();
        rx_level = 5'd0;
        char_tick = 1'b1;
        @(negedge clk);
        char_tick = 1'b0;
        check("R4 empty clears flag", tmo_pending, 1'b0);
        tick(N);
        check("R4 no timeout when empty", tmo_pending, 1'b0);
        rx_level = 5'd1;
        tick(N - 1);
        check("R4 full count needed after refill", tmo_pending, 1'b0);
        tick(1);
        check("R4 timeout after refill", tmo_pending, 1'b1);
    endtask

    task automatic t_enable();
        rda_int_en = 1'b0;
        @(negedge clk);
        check("R5 irq masked", tmo_irq, 1'b0);
        check("R5 pending unaffected by mask", tmo_pending, 1'b1);
        strobe_pop();
        tick(N);
        check("R5 counting while masked", tmo_pending, 1'b1);
        check("R5 irq low while masked", tmo_irq, 1'b0);
        rda_int_en = 1'b1;
        #0.5;
        check("R5 irq shows at once on enable", tmo_irq, 1'b1);
    endtask

    task automatic t_saturate();
        tick(5 * N);
        check("R6 flag stays set after many ticks", tmo_pending, 1'b1);
        strobe_pop();
        tick(N - 1);
        check("R6 count did not wrap", tmo_pending, 1'b0);
        tick(1);
        check("R6 next timeout exact", tmo_pending, 1'b1);
    endtask

    initial begin
        t_reset();
        t_nonfifo();
        t_basic();
        t_access();
        t_empty();
        t_enable();
        t_saturate();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule